// File: doc/BRIEF.md
# Frame-Master Serial Payload Timing Generator

This block is the transmit timing core of a framer that sets the frame timing itself. It counts bit periods across a fixed-length outbound frame. Terminal equipment sends serial payload on one data pin, and that pin is sampled on the rising edge of a bit clock that both sides share. The block produces a one-period frame strobe during the last position of every frame. The far end answers the strobe by presenting the first bit of the next frame in the period that follows.

One period before every overhead position, the block raises an overhead warning so that the far end holds its next payload bit back by one period. The block merges the sampled payload with locally generated overhead bits into one registered serial stream. At overhead positions the overhead bit is used, and any payload value on the data pin is discarded.

The overhead positions form a parameterized list: a start slot, a count and a stride. By default they are positions 0 to 11 of a 1536-period frame. A synchronous active-high reset restarts the frame at position 0.

Top module: `frame_master_tx_gen`

## Requirements
- R1: The bit position advances by one on every clock while reset is low, and wraps from FRAME_LEN-1 (default 1535) to 0. Consecutive frame strobes are therefore exactly FRAME_LEN (default 1536) clocks apart.
- R2: `frame_strobe` is high for exactly one clock period, which is the period in which position FRAME_LEN-1 is processed. The first payload bit of the next frame is due in the following period, which is position 0.
- R3: `oh_warn` is high in the period of position p if and only if position (p+1) mod FRAME_LEN is an overhead position. With the defaults it is high at positions 1535 and 0 to 10.
- R4: The overhead positions are OH_START + k*OH_STRIDE for k = 0 to OH_COUNT-1, so each frame holds exactly OH_COUNT warning periods. The defaults give positions 0 to 11.
- R5: When position p is an overhead position, `ser_out` in the period after p equals `oh_bit_in` as sampled at the clock edge that ends period p.
- R6: When position p is not an overhead position, `ser_out` in the period after p equals `pay_in` as sampled at the edge that ends period p. The value on `pay_in` during an overhead position has no effect on `ser_out`.
- R7: While `rst` is high, `frame_strobe` and `oh_warn` are low. After any clock edge that samples `rst` high, `ser_out` is low. The first period after the edge that samples `rst` low is position 0, and this holds even when reset arrives in mid-frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared bit clock; all sampling happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pay_in | input | 1 | Serial payload from the terminal equipment |
| oh_bit_in | input | 1 | Locally generated overhead bit for the current position |
| frame_strobe | output | 1 | High during the last position of each frame |
| oh_warn | output | 1 | High one period before each overhead position |
| ser_out | output | 1 | Merged serial stream, one period behind the position it carries |

## Verification
The merge is tried with three input patterns. A constant-one payload against a zero overhead bit shows at once which source fed each position. Payload and overhead that toggle at different rates expose a select that is one position early or late. A pseudo-random stream on both inputs catches sampling in the wrong period. A mid-frame reset shows whether the position restarts at 0 rather than continuing. Counting strobe spacing and warnings per frame separates a wrong frame length or overhead list from a warning given in the wrong period.

// File: rtl/fmtx_pkg.sv
`timescale 1ns/1ps
package fmtx_pkg;

   typedef enum logic {
      SRC_PAYLOAD  = 1'b0,
      SRC_OVERHEAD = 1'b1
   } fmtx_src_e;

   // highest slot touched by an overhead list of the given shape
   function automatic int unsigned oh_last_slot(input int unsigned start,
                                                input int unsigned count,
                                                input int unsigned stride);
      return start + (count - 1) * stride;
   endfunction

endpackage

// File: rtl/fmtx_pos_counter.sv
`timescale 1ns/1ps
module fmtx_pos_counter #(
   parameter int unsigned FRAME_LEN = 1536,
   parameter int unsigned POS_W     = 11
) (
   input  logic             clk,
   input  logic             rst,
   output logic [POS_W-1:0] pos,
   output logic [POS_W-1:0] pos_ahead,
   output logic             at_last
);

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

   logic [POS_W-1:0] pos_q;

   always_comb begin
      at_last   = (pos_q == LAST_POS);
      pos_ahead = at_last ? '0 : pos_q + POS_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) pos_q <= '0;
      else     pos_q <= pos_ahead;
   end

   assign pos = pos_q;

endmodule

// File: rtl/fmtx_oh_map.sv
`timescale 1ns/1ps
module fmtx_oh_map #(
   parameter int unsigned POS_W     = 11,
   parameter int unsigned OH_START  = 0,
   parameter int unsigned OH_COUNT  = 12,
   parameter int unsigned OH_STRIDE = 1
) (
   input  logic [POS_W-1:0] pos,
   output logic             hit
);

   localparam int unsigned OH_END = OH_START + (OH_COUNT - 1) * OH_STRIDE;

   generate
      if (OH_STRIDE == 1 && OH_START == 0) begin : g_low_range
         assign hit = (pos <= POS_W'(OH_END));
      end else if (OH_STRIDE == 1) begin : g_range
         assign hit = (pos >= POS_W'(OH_START)) && (pos <= POS_W'(OH_END));
      end else begin : g_sparse
         logic [OH_COUNT-1:0] hit_vec;
         for (genvar k = 0; k < OH_COUNT; k++) begin : g_slot
            localparam int unsigned SLOT = OH_START + k * OH_STRIDE;
            assign hit_vec[k] = (pos == POS_W'(SLOT));
         end
         assign hit = |hit_vec;
      end
   endgenerate

endmodule

// File: rtl/fmtx_merge.sv
`timescale 1ns/1ps
module fmtx_merge
   import fmtx_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  fmtx_src_e src,
   input  logic      pay_in,
   input  logic      oh_bit_in,
   output logic      ser_out
);

   logic ser_q;

   always_ff @(posedge clk) begin
      if (rst) ser_q <= 1'b0;
      else     ser_q <= (src == SRC_OVERHEAD) ? oh_bit_in : pay_in;
   end

   assign ser_out = ser_q;

endmodule

// File: rtl/frame_master_tx_gen.sv
`timescale 1ns/1ps
module frame_master_tx_gen
   import fmtx_pkg::*;
#(
   parameter int unsigned FRAME_LEN = 1536,
   parameter int unsigned OH_START  = 0,
   parameter int unsigned OH_COUNT  = 12,
   parameter int unsigned OH_STRIDE = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic pay_in,
   input  logic oh_bit_in,
   output logic frame_strobe,
   output logic oh_warn,
   output logic ser_out
);

   localparam int unsigned POS_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;

   generate
      if (FRAME_LEN < 2) begin : g_bad_len
         $error("frame_master_tx_gen: FRAME_LEN must be at least 2");
      end
      if (OH_COUNT < 1 || OH_STRIDE < 1) begin : g_bad_list
         $error("frame_master_tx_gen: OH_COUNT and OH_STRIDE must be at least 1");
      end
      if (oh_last_slot(OH_START, OH_COUNT, OH_STRIDE) >= FRAME_LEN) begin : g_bad_fit
         $error("frame_master_tx_gen: overhead list runs past the frame end");
      end
   endgenerate

   logic [POS_W-1:0] cur_pos;
   logic [POS_W-1:0] next_pos;
   logic             last_slot;
   logic             oh_now;
   logic             oh_next;
   fmtx_src_e        src_sel;

   fmtx_pos_counter #(
      .FRAME_LEN (FRAME_LEN),
      .POS_W     (POS_W)
   ) pos_i (
      .clk       (clk),
      .rst       (rst),
      .pos       (cur_pos),
      .pos_ahead (next_pos),
      .at_last   (last_slot)
   );

   fmtx_oh_map #(
      .POS_W     (POS_W),
      .OH_START  (OH_START),
      .OH_COUNT  (OH_COUNT),
      .OH_STRIDE (OH_STRIDE)
   ) map_now_i (
      .pos (cur_pos),
      .hit (oh_now)
   );

   fmtx_oh_map #(
      .POS_W     (POS_W),
      .OH_START  (OH_START),
      .OH_COUNT  (OH_COUNT),
      .OH_STRIDE (OH_STRIDE)
   ) map_next_i (
      .pos (next_pos),
      .hit (oh_next)
   );

   assign src_sel = oh_now ? SRC_OVERHEAD : SRC_PAYLOAD;

   fmtx_merge merge_i (
      .clk       (clk),
      .rst       (rst),
      .src       (src_sel),
      .pay_in    (pay_in),
      .oh_bit_in (oh_bit_in),
      .ser_out   (ser_out)
   );

   assign frame_strobe = !rst && last_slot;
   assign oh_warn      = !rst && oh_next;

endmodule

// File: rtl/fmtx_chk.sv
`timescale 1ns/1ps
module fmtx_chk #(
   parameter int unsigned FRAME_LEN = 1536,
   parameter int unsigned POS_W     = 11,
   parameter int unsigned OH_START  = 0,
   parameter int unsigned OH_COUNT  = 12,
   parameter int unsigned OH_STRIDE = 1
) (
   input logic             clk,
   input logic             rst,
   input logic             pay_in,
   input logic             oh_bit_in,
   input logic             frame_strobe,
   input logic             oh_warn,
   input logic             ser_out,
   input logic [POS_W-1:0] pos
);

   localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

   function automatic logic slot_is_oh(input int unsigned p);
      for (int unsigned k = 0; k < OH_COUNT; k++)
         if (p == OH_START + k * OH_STRIDE) return 1'b1;
      return 1'b0;
   endfunction

   logic cur_oh;
   always_comb cur_oh = slot_is_oh(int'(pos));

   // R2
   strobe_last_chk: assert property (@(posedge clk) disable iff (rst)
      frame_strobe |-> pos == LAST);
   // R2
   strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
      frame_strobe |=> !frame_strobe);
   // R1
   pos_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      pos == LAST |=> pos == '0);
   // R1
   pos_step_chk: assert property (@(posedge clk) disable iff (rst)
      pos != LAST |=> pos == $past(pos) + POS_W'(1));
   // R3
   warn_ahead_chk: assert property (@(posedge clk) disable iff (rst)
      oh_warn |=> cur_oh);
   // R5
   oh_merge_chk: assert property (@(posedge clk) disable iff (rst)
      cur_oh |=> ser_out == $past(oh_bit_in));
   // R6
   pay_merge_chk: assert property (@(posedge clk) disable iff (rst)
      !cur_oh |=> ser_out == $past(pay_in));
   // R7
   rst_quiet_chk: assert property (@(posedge clk)
      rst |-> !frame_strobe && !oh_warn);
   // R7
   rst_ser_chk: assert property (@(posedge clk)
      rst |=> !ser_out);

endmodule

bind frame_master_tx_gen fmtx_chk #(
   .FRAME_LEN (FRAME_LEN),
   .POS_W     (POS_W),
   .OH_START  (OH_START),
   .OH_COUNT  (OH_COUNT),
   .OH_STRIDE (OH_STRIDE)
) chk_i (
   .clk          (clk),
   .rst          (rst),
   .pay_in       (pay_in),
   .oh_bit_in    (oh_bit_in),
   .frame_strobe (frame_strobe),
   .oh_warn      (oh_warn),
   .ser_out      (ser_out),
   .pos          (cur_pos)
);

// File: tb/frame_master_tx_gen_tb_top.sv
`timescale 1ns/1ps
module frame_master_tx_gen_tb_top;

   localparam int unsigned FLEN = 1536;
   localparam int unsigned OHS  = 0;
   localparam int unsigned OHC  = 12;
   localparam int unsigned OHST = 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pay_in = 1'b0;
   logic oh_bit_in = 1'b0;
   logic frame_strobe, oh_warn, ser_out;

   always #4 clk = ~clk;

   int errors = 0;
   int checks = 0;
   int unsigned exp_pos = 0;
   logic exp_ser = 1'b0;
   string ser_req = "R7";
   longint cyc = 0;
   longint last_strobe = -1;
   int warn_cnt = 0;
   logic [15:0] lfsr = 16'hACE1;

   frame_master_tx_gen #(
      .FRAME_LEN (FLEN),
      .OH_START  (OHS),
      .OH_COUNT  (OHC),
      .OH_STRIDE (OHST)
   ) dut_i (
      .clk          (clk),
      .rst          (rst),
      .pay_in       (pay_in),
      .oh_bit_in    (oh_bit_in),
      .frame_strobe (frame_strobe),
      .oh_warn      (oh_warn),
      .ser_out      (ser_out)
   );

   // R4: overhead slots are OHS + k*OHST, k below OHC
   function automatic bit is_oh(input int unsigned p);
      for (int unsigned k = 0; k < OHC; k++)
         if (p == OHS + k * OHST) return 1'b1;
      return 1'b0;
   endfunction

   task automatic check1(input string req, input logic act, input logic exp,
                         input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s at pos %0d: actual=%b expected=%b",
                  req, what, exp_pos, act, exp);
      end
   endtask

   task automatic check_int(input string req, input longint act, input longint exp,
                            input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // one bit period; entered just after a falling edge, leaves on the next one
   task automatic tick(input int mode);
      case (mode)
         0: begin pay_in = 1'b1; oh_bit_in = 1'b0; end
         1: begin pay_in = cyc[0]; oh_bit_in = ~cyc[1]; end
         default: begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pay_in = lfsr[0];
            oh_bit_in = lfsr[5];
         end
      endcase
      #1;
      check1("R2", frame_strobe, exp_pos == FLEN - 1, "frame_strobe");
      check1("R3", oh_warn, is_oh((exp_pos + 1) % FLEN), "oh_warn");
      check1(ser_req, ser_out, exp_ser, "ser_out");
      if (oh_warn === 1'b1) warn_cnt++;
      if (frame_strobe === 1'b1) begin
         // R1: strobe spacing equals frame length
         if (last_strobe >= 0) check_int("R1", cyc - last_strobe, FLEN, "strobe spacing");
         last_strobe = cyc;
      end
      exp_ser = is_oh(exp_pos) ? oh_bit_in : pay_in;
      ser_req = is_oh(exp_pos) ? "R5" : "R6";
      exp_pos = (exp_pos + 1) % FLEN;
      cyc++;
      @(negedge clk);
   endtask

   task automatic do_reset(input int hold);
      rst = 1'b1;
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         #1;
         check1("R7", frame_strobe, 1'b0, "frame_strobe in reset");
         check1("R7", oh_warn, 1'b0, "oh_warn in reset");
         check1("R7", ser_out, 1'b0, "ser_out in reset");
      end
      rst = 1'b0;
      exp_pos = 0;
      exp_ser = 1'b0;
      ser_req = "R7";
      last_strobe = -1;
      pay_in = 1'b0;
      oh_bit_in = 1'b0;
   endtask

   task automatic t_pattern(input int mode, input int n);
      for (int i = 0; i < n; i++) tick(mode);
   endtask

   // R4: one full frame from position 0 carries OHC warnings
   task automatic t_oh_window();
      while (exp_pos != 0) tick(2);
      warn_cnt = 0;
      for (int i = 0; i < FLEN; i++) tick(2);
      check_int("R4", warn_cnt, OHC, "warnings per frame");
   endtask

   // R7: reset in mid-frame restarts the frame at position 0
   task automatic t_mid_reset();
      t_pattern(1, 700);
      do_reset(3);
      t_pattern(1, FLEN + 40);
   endtask

   initial begin
      @(negedge clk);
      do_reset(4);
      t_pattern(0, 2 * FLEN + 20);
      t_pattern(1, FLEN + 10);
      t_pattern(2, FLEN + 10);
      t_oh_window();
      t_mid_reset();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule